// File: doc/BRIEF.md
# Tester Pin Timing Format Generator

This block is the timing engine behind one pin of a digital tester. It takes a stream of vectors. Each vector carries one pattern bit, a flag that picks force or compare, and the pin setup for that vector: a drive format and a timing window. Each accepted vector lasts a fixed number of fine ticks, one tick per clock. During that time the block either shapes the bit into a timed drive waveform on the pin, or, in compare mode, turns its driver off and checks the value the device returns at one strobe tick.

The timing window is a start tick and a length in ticks. It comes from one of three built-in presets or from explicit setup inputs. At the default scale of 500 ps per tick, a vector is 200 ns long (400 ticks). The presets are 0 ns/100 ns, 40 ns/100 ns and 20 ns/80 ns, given as start/length. Three drive shapes are offered: a level that changes at the window start, a pulse that returns to zero, and a pulse that returns to the complement of the bit. A compare result leaves through its own valid/ready port.

Vectors arrive on a valid/ready stream. A vector is taken only on the last tick of the current vector, or at any tick when the channel is idle. Once `vec_valid` is raised, the vector and its setup must stay stable until the handshake. Results use their own valid/ready port. A result that has not been taken holds its value, and it stops new vectors from being accepted until the consumer takes it. A new vector is also refused on a tick where a strobe is being taken, so two results can never compete for the single result slot.

Top module: `tfg_pin_channel`

## Requirements
- R1: After reset, `drv_en`, `drv_lvl` and `res_valid` are 0 and `vec_ready` is 1.
- R2: An accepted vector occupies exactly CYCLE_TICKS clocks (ticks 0 to CYCLE_TICKS-1). `vec_ready` can only be 1 on the last tick or while idle. The tick count advances by one on every clock within a vector.
- R3: The window is set by `cfg_phase`: 0 gives start 0, length 200; 1 gives start 80, length 200; 2 gives start 40, length 160; 3 takes `cfg_delay`/`cfg_width`. The window covers the ticks t with start <= t < min(start+length, CYCLE_TICKS). The setup is captured when the vector is accepted.
- R4: Format 0 (delayed level), and the spare code 3 which acts the same: before the window start the pin keeps its previous level. From the window start to the end of the vector, the pin drives the bit.
- R5: Format 1 (return to zero): the pin drives the bit inside the window and 0 outside it.
- R6: Format 2 (return to inverse): the pin drives the bit inside the window and its complement outside it.
- R7: `drv_en` is 0 for the whole of a compare vector and 1 for the whole of a force vector.
- R8: A compare vector strobes `pin_in` once, on the last tick of its window (tick 0 if the window ends at 0). On the next clock, `res_valid` rises with `res_fail` = `pin_in` XOR bit. A force vector produces no result.
- R9: While `res_valid` is 1 and `res_ready` is 0, the result is held unchanged and `vec_ready` is 0. `vec_ready` is also 0 on a tick where a strobe is taken.
- R10: When no vector is accepted at a boundary, the channel goes idle and `drv_lvl`/`drv_en` hold their last values until the next vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low reset |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector taken this clock if valid |
| vec_bit | input | 1 | Pattern bit |
| vec_cmp | input | 1 | 1 = compare, 0 = force |
| cfg_fmt | input | 2 | Drive format code |
| cfg_phase | input | 2 | Window preset select |
| cfg_delay | input | TW | Custom window start, ticks |
| cfg_width | input | TW | Custom window length, ticks |
| pin_in | input | 1 | Value returned from the device pin |
| drv_lvl | output | 1 | Drive level |
| drv_en | output | 1 | Driver enable |
| res_valid | output | 1 | Compare result available |
| res_ready | input | 1 | Result consumer ready |
| res_fail | output | 1 | 1 = mismatch at strobe |

## Verification
The embedded assertions check, on every clock, the properties that hold locally. Ready only appears at a vector boundary. The tick count steps by one inside a vector. The driver stays off in compare mode. Return-to-zero is low outside the window. A pending result is held and never overrun. The idle channel keeps its outputs. The exact placement of each edge for every format and window preset, the strobe tick, the delay before a result appears, the stall under result back-pressure, and the clipping of long or empty custom windows can only be shown by the bench scenarios. There, a tick-by-tick model is compared with the outputs.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
  typedef enum logic [1:0] {
    FMT_LEVEL_DLY = 2'd0,
    FMT_RET_ZERO  = 2'd1,
    FMT_RET_INV   = 2'd2,
    FMT_SPARE     = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    WIN_P0     = 2'd0,
    WIN_P1     = 2'd1,
    WIN_P2     = 2'd2,
    WIN_CUSTOM = 2'd3
  } win_sel_e;

  localparam int unsigned DEF_CYCLE_TICKS = 400;
  localparam int unsigned DEF_P0_START = 0;
  localparam int unsigned DEF_P0_LEN   = 200;
  localparam int unsigned DEF_P1_START = 80;
  localparam int unsigned DEF_P1_LEN   = 200;
  localparam int unsigned DEF_P2_START = 40;
  localparam int unsigned DEF_P2_LEN   = 160;
endpackage

// File: rtl/tfg_window_resolve.sv
module tfg_window_resolve
  import tfg_pkg::*;
#(
  parameter int unsigned CYCLE_TICKS = DEF_CYCLE_TICKS,
  parameter int unsigned TW = $clog2(CYCLE_TICKS),
  parameter int unsigned P0_START = DEF_P0_START,
  parameter int unsigned P0_LEN = DEF_P0_LEN,
  parameter int unsigned P1_START = DEF_P1_START,
  parameter int unsigned P1_LEN = DEF_P1_LEN,
  parameter int unsigned P2_START = DEF_P2_START,
  parameter int unsigned P2_LEN = DEF_P2_LEN
) (
  input  logic [1:0]    sel,
  input  logic [TW-1:0] cust_start,
  input  logic [TW-1:0] cust_len,
  output logic [TW-1:0] win_start,
  output logic [TW:0]   win_end,
  output logic [TW-1:0] win_strobe
);
  localparam logic [TW:0] CYC_W = (TW+1)'(CYCLE_TICKS);

  logic [TW-1:0] len;
  logic [TW:0]   sum;

  always_comb begin
    unique case (win_sel_e'(sel))
      WIN_P0:  begin win_start = TW'(P0_START); len = TW'(P0_LEN); end
      WIN_P1:  begin win_start = TW'(P1_START); len = TW'(P1_LEN); end
      WIN_P2:  begin win_start = TW'(P2_START); len = TW'(P2_LEN); end
      default: begin win_start = cust_start;    len = cust_len;    end
    endcase
  end

  always_comb begin
    sum = {1'b0, win_start} + {1'b0, len};
    win_end = (sum > CYC_W) ? CYC_W : sum;
    win_strobe = (win_end == '0) ? '0 : TW'(win_end - 1'b1);
  end
endmodule

// File: rtl/tfg_sequencer.sv
module tfg_sequencer #(
  parameter int unsigned CYCLE_TICKS = 400,
  parameter int unsigned TW = $clog2(CYCLE_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vec_valid,
  output logic          vec_ready,
  input  logic          vec_bit,
  input  logic          vec_cmp,
  input  logic [1:0]    fmt_in,
  input  logic [TW-1:0] start_in,
  input  logic [TW:0]   end_in,
  input  logic [TW-1:0] strobe_in,
  input  logic          res_block,
  output logic          active,
  output logic          bit_q,
  output logic          cmp_q,
  output logic [1:0]    fmt_q,
  output logic          in_win,
  output logic          started,
  output logic          strobe_now,
  output logic          take
);
  localparam logic [TW-1:0] LAST_TICK = TW'(CYCLE_TICKS - 1);

  logic [TW-1:0] tick;
  logic [TW-1:0] start_q;
  logic [TW:0]   end_q;
  logic [TW-1:0] strobe_q;
  logic          boundary;

  assign boundary   = !active || (tick == LAST_TICK);
  assign strobe_now = active && cmp_q && (tick == strobe_q);
  assign vec_ready  = boundary && !strobe_now && !res_block;
  assign take       = vec_valid && vec_ready;
  assign started    = tick >= start_q;
  assign in_win     = started && ({1'b0, tick} < end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      tick     <= '0;
      bit_q    <= 1'b0;
      cmp_q    <= 1'b0;
      fmt_q    <= '0;
      start_q  <= '0;
      end_q    <= '0;
      strobe_q <= '0;
    end else if (take) begin
      active   <= 1'b1;
      tick     <= '0;
      bit_q    <= vec_bit;
      cmp_q    <= vec_cmp;
      fmt_q    <= fmt_in;
      start_q  <= start_in;
      end_q    <= end_in;
      strobe_q <= strobe_in;
    end else if (active && tick == LAST_TICK) begin
      active <= 1'b0;
      tick   <= '0;
    end else if (active) begin
      tick <= tick + 1'b1;
    end
  end

  AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready |-> (!active || tick == LAST_TICK)); // R2
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick != LAST_TICK) |=> (active && tick == $past(tick) + 1'b1)); // R2
endmodule

// File: rtl/tfg_wave_shaper.sv
module tfg_wave_shaper
  import tfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       cmp_q,
  input  logic [1:0] fmt_q,
  input  logic       bit_q,
  input  logic       in_win,
  input  logic       started,
  output logic       drv_lvl,
  output logic       drv_en
);
  logic lvl_hold;
  logic en_hold;

  always_comb begin
    if (!active) begin
      drv_en  = en_hold;
      drv_lvl = lvl_hold;
    end else if (cmp_q) begin
      drv_en  = 1'b0;
      drv_lvl = lvl_hold;
    end else begin
      drv_en = 1'b1;
      unique case (fmt_e'(fmt_q))
        FMT_RET_ZERO: drv_lvl = in_win & bit_q;
        FMT_RET_INV:  drv_lvl = in_win ? bit_q : ~bit_q;
        default:      drv_lvl = started ? bit_q : lvl_hold;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_hold <= 1'b0;
      en_hold  <= 1'b0;
    end else begin
      lvl_hold <= drv_lvl;
      en_hold  <= drv_en;
    end
  end

  AST_RI_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmp_q && fmt_q == FMT_RET_INV && !in_win) |-> (drv_lvl != bit_q)); // R6
endmodule

// File: rtl/tfg_strobe_slot.sv
module tfg_strobe_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_now,
  input  logic pin_in,
  input  logic exp_bit,
  input  logic res_ready,
  output logic res_valid,
  output logic res_fail,
  output logic res_block
);
  assign res_block = res_valid && !res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fail  <= 1'b0;
    end else if (strobe_now) begin
      res_valid <= 1'b1;
      res_fail  <= pin_in ^ exp_bit;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fail))); // R9
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_now |-> !(res_valid && !res_ready)); // R9
endmodule

// File: rtl/tfg_pin_channel.sv
module tfg_pin_channel
  import tfg_pkg::*;
#(
  parameter int unsigned CYCLE_TICKS = DEF_CYCLE_TICKS,
  parameter int unsigned P0_START = DEF_P0_START,
  parameter int unsigned P0_LEN = DEF_P0_LEN,
  parameter int unsigned P1_START = DEF_P1_START,
  parameter int unsigned P1_LEN = DEF_P1_LEN,
  parameter int unsigned P2_START = DEF_P2_START,
  parameter int unsigned P2_LEN = DEF_P2_LEN,
  localparam int unsigned TW = $clog2(CYCLE_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vec_valid,
  output logic          vec_ready,
  input  logic          vec_bit,
  input  logic          vec_cmp,
  input  logic [1:0]    cfg_fmt,
  input  logic [1:0]    cfg_phase,
  input  logic [TW-1:0] cfg_delay,
  input  logic [TW-1:0] cfg_width,
  input  logic          pin_in,
  output logic          drv_lvl,
  output logic          drv_en,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_fail
);
  logic [TW-1:0] w_start;
  logic [TW:0]   w_end;
  logic [TW-1:0] w_strobe;
  logic          active, bit_q, cmp_q, in_win, started, strobe_now, take, res_block;
  logic [1:0]    fmt_q;

  tfg_window_resolve #(
    .CYCLE_TICKS(CYCLE_TICKS), .TW(TW),
    .P0_START(P0_START), .P0_LEN(P0_LEN),
    .P1_START(P1_START), .P1_LEN(P1_LEN),
    .P2_START(P2_START), .P2_LEN(P2_LEN)
  ) u_win (
    .sel(cfg_phase), .cust_start(cfg_delay), .cust_len(cfg_width),
    .win_start(w_start), .win_end(w_end), .win_strobe(w_strobe)
  );

  tfg_sequencer #(.CYCLE_TICKS(CYCLE_TICKS), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_bit(vec_bit), .vec_cmp(vec_cmp), .fmt_in(cfg_fmt),
    .start_in(w_start), .end_in(w_end), .strobe_in(w_strobe),
    .res_block(res_block),
    .active(active), .bit_q(bit_q), .cmp_q(cmp_q), .fmt_q(fmt_q),
    .in_win(in_win), .started(started), .strobe_now(strobe_now), .take(take)
  );

  tfg_wave_shaper u_wave (
    .clk(clk), .rst_n(rst_n),
    .active(active), .cmp_q(cmp_q), .fmt_q(fmt_q), .bit_q(bit_q),
    .in_win(in_win), .started(started),
    .drv_lvl(drv_lvl), .drv_en(drv_en)
  );

  tfg_strobe_slot u_slot (
    .clk(clk), .rst_n(rst_n),
    .strobe_now(strobe_now), .pin_in(pin_in), .exp_bit(bit_q),
    .res_ready(res_ready),
    .res_valid(res_valid), .res_fail(res_fail), .res_block(res_block)
  );

  AST_CMP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmp_q) |-> !drv_en); // R7
  AST_FORCE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmp_q) |-> drv_en); // R7
  AST_RZ_LOW_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmp_q && fmt_q == FMT_RET_ZERO && !in_win) |-> !drv_lvl); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !take) |=> ($stable(drv_lvl) && $stable(drv_en))); // R10
  AST_FORCE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmp_q && !res_valid) |=> !res_valid); // R8
endmodule

// File: tb/tfg_pin_channel_test.sv
`timescale 1ns/1ps
module tfg_pin_channel_test;
  localparam int CYC = 400;
  localparam int TW = $clog2(CYC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_valid = 1'b0, vec_bit = 1'b0, vec_cmp = 1'b0, pin_in = 1'b0, res_ready = 1'b1;
  logic [1:0] cfg_fmt = '0, cfg_phase = '0;
  logic [TW-1:0] cfg_delay = '0, cfg_width = '0;
  logic vec_ready, drv_lvl, drv_en, res_valid, res_fail;

  always #2 clk = ~clk;

  tfg_pin_channel uut (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_bit(vec_bit), .vec_cmp(vec_cmp), .cfg_fmt(cfg_fmt), .cfg_phase(cfg_phase),
    .cfg_delay(cfg_delay), .cfg_width(cfg_width), .pin_in(pin_in),
    .drv_lvl(drv_lvl), .drv_en(drv_en), .res_valid(res_valid),
    .res_ready(res_ready), .res_fail(res_fail)
  );

  typedef struct {
    bit b; bit c; int fmt; int ph; int dly; int wid; bit pin; int gap;
  } vec_t;
  vec_t q[$];

  int total = 0, bad = 0, cyc = 0;
  int exp_results = 0, got_results = 0;
  bit took = 0, running = 0;

  // model state
  bit m_act = 0, m_bit = 0, m_cmp = 0, m_lh = 0, m_eh = 0, m_rv = 0, m_rf = 0;
  int m_t = 0, m_fmt = 0, m_dly = 0, m_end = 0, m_stb = 0;

  task automatic chk(string req, int actv, int expv);
    total++;
    if (actv != expv) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, actv, expv);
    end
  endtask

  task automatic add(bit b, bit c, int fmt, int ph, int dly, int wid, bit pin, int gap);
    vec_t v;
    v.b = b; v.c = c; v.fmt = fmt; v.ph = ph; v.dly = dly; v.wid = wid; v.pin = pin; v.gap = gap;
    q.push_back(v);
    if (c) exp_results++;
  endtask

  // Driver: changes inputs on the falling edge
  initial begin
    int gap_left;
    gap_left = -1;
    forever begin
      @(negedge clk);
      if (!running) continue;
      res_ready = !(cyc >= 3000 && cyc < 4500);
      if (took) begin
        pin_in = q[0].pin;
        void'(q.pop_front());
        vec_valid = 1'b0;
        gap_left = -1;
      end
      if (q.size() > 0) begin
        if (gap_left < 0) gap_left = q[0].gap;
        if (gap_left > 0) begin
          gap_left--;
          vec_valid = 1'b0;
        end else begin
          vec_valid = 1'b1;
          vec_bit = q[0].b; vec_cmp = q[0].c;
          cfg_fmt = 2'(q[0].fmt); cfg_phase = 2'(q[0].ph);
          cfg_delay = TW'(q[0].dly); cfg_width = TW'(q[0].wid);
        end
      end else begin
        vec_valid = 1'b0;
      end
    end
  end

  // Checker: reference model stepped once per tick, compared just after inputs settle
  initial begin
    bit bnd, stb, ready, lvl, en, inw, acc;
    string lreq, ereq;
    int s, l, e;
    forever begin
      @(negedge clk);
      #1;
      if (!running) continue;
      cyc++;
      bnd = !m_act || (m_t == CYC - 1);
      stb = m_act && m_cmp && (m_t == m_stb);
      ready = bnd && !stb && !(m_rv && !res_ready);
      inw = (m_t >= m_dly) && (m_t < m_end);
      if (!m_act) begin
        en = m_eh; lvl = m_lh; lreq = "R10"; ereq = "R10";
      end else if (m_cmp) begin
        en = 0; lvl = m_lh; lreq = "R7"; ereq = "R7";
      end else begin
        en = 1; ereq = "R7";
        case (m_fmt)
          1: begin lvl = inw & m_bit; lreq = "R5"; end
          2: begin lvl = inw ? m_bit : !m_bit; lreq = "R6"; end
          default: begin lvl = (m_t >= m_dly) ? m_bit : m_lh; lreq = "R4"; end
        endcase
      end
      chk((stb || m_rv) ? "R9" : "R2", vec_ready, ready);
      chk(ereq, drv_en, en);
      chk(lreq, drv_lvl, lvl);
      chk("R8", res_valid, m_rv);
      if (m_rv) chk("R8", res_fail, m_rf);
      took = vec_valid && vec_ready;
      if (res_valid && res_ready) got_results++;
      // advance model
      m_lh = lvl; m_eh = en;
      if (stb) begin m_rv = 1; m_rf = pin_in ^ m_bit; end
      else if (m_rv && res_ready) m_rv = 0;
      acc = vec_valid && ready;
      if (acc) begin
        case (cfg_phase)
          2'd0: begin s = 0;  l = 200; end
          2'd1: begin s = 80; l = 200; end
          2'd2: begin s = 40; l = 160; end
          default: begin s = int'(cfg_delay); l = int'(cfg_width); end
        endcase
        e = (s + l > CYC) ? CYC : s + l;
        m_act = 1; m_t = 0; m_bit = vec_bit; m_cmp = vec_cmp; m_fmt = int'(cfg_fmt);
        m_dly = s; m_end = e; m_stb = (e == 0) ? 0 : e - 1;
      end else if (m_act && m_t == CYC - 1) begin
        m_act = 0; m_t = 0;
      end else if (m_act) begin
        m_t++;
      end
    end
  end

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R3 presets and custom windows, R4-R6 shapes, R7-R9 compare, R10 idle gaps
    add(1, 0, 1, 2, 0, 0, 0, 0);     // R5 return-to-zero, preset 2
    add(0, 0, 1, 2, 0, 0, 0, 0);     // R5 bit 0 stays low
    add(1, 0, 0, 0, 0, 0, 0, 0);     // R4 level at tick 0
    add(0, 0, 0, 1, 0, 0, 0, 0);     // R4 holds 1 until tick 80
    add(1, 0, 2, 2, 0, 0, 0, 3);     // R6 after idle gap (R10)
    add(0, 0, 2, 1, 0, 0, 0, 0);     // R6 bit 0
    add(1, 0, 3, 3, 10, 5, 0, 0);    // R4 spare code acts as level
    add(1, 1, 0, 0, 0, 0, 1, 0);     // R8 pass
    add(1, 1, 0, 1, 0, 0, 0, 0);     // R8 fail, result pending under back-pressure (R9)
    add(0, 1, 0, 2, 0, 0, 1, 0);     // R9 stall at boundary
    add(0, 1, 0, 3, 0, 400, 0, 0);   // R8 strobe on last tick, ready gap (R9)
    add(1, 1, 0, 3, 0, 0, 0, 0);     // R3 empty window, strobe tick 0
    add(1, 0, 1, 3, 50, 0, 0, 2);    // R3 empty window, RZ never high
    add(0, 0, 2, 3, 390, 100, 0, 0); // R3 clipped end
    add(1, 0, 1, 3, 0, 400, 0, 0);   // R5 full-cycle window
    add(0, 1, 0, 3, 399, 1, 1, 0);   // R8 strobe last tick
    add(1, 0, 0, 2, 0, 0, 0, 5);     // R10 hold through gap
    repeat (3) @(posedge clk);
    #1;
    total++; if (vec_ready !== 1'b1) begin bad++; $display("FAIL R1: vec_ready actual=%0d expected=1", vec_ready); end
    total++; if (drv_en !== 1'b0) begin bad++; $display("FAIL R1: drv_en actual=%0d expected=0", drv_en); end
    total++; if (drv_lvl !== 1'b0) begin bad++; $display("FAIL R1: drv_lvl actual=%0d expected=0", drv_lvl); end
    total++; if (res_valid !== 1'b0) begin bad++; $display("FAIL R1: res_valid actual=%0d expected=0", res_valid); end
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    wait (q.size() == 0);
    repeat (CYC + 20) @(negedge clk);
    chk("R8", got_results, exp_results);
    chk("R9", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule